// File: doc/BRIEF.md
# Folded Lowpass Decimate-by-Eight Filter

This block sits between a 12-bit converter and a downstream filter bank. Samples arrive at 600 Hz, one per clock-wide strobe. The block low-pass filters them with a 49-tap linear-phase FIR and keeps one result out of every eight, so the filter bank is fed at 75 Hz. Every sample is written into a circular delay line. Results are only worked out for the output phase that is kept.

The coefficients are symmetric, so each pair of taps equally far from the centre is summed before it is multiplied. One multiplier then walks through 24 pair products and one centre-tap product, 25 multiply-accumulate cycles in all. The full-precision sum is rounded, saturated to 16 bits and presented with a one-clock valid pulse. Taps that reach back past the most recent reset count as zero samples.

Top module: `lpd_decim_fir`

## Requirements
- R1: While reset is applied and after its release, until the first result, `out_vld` is 0 and `out_smp` is 0.
- R2: Exactly one result is produced for every eight accepted strobes since reset, after the 8th, 16th, 24th strobe and so on.
- R3: A result equals the sum over k = 0..48 of h[k]·x[n−k], where x[n] is the sample taken with the 8th, 16th, … strobe and h[k] = 64·(min(k, 48−k) + 1). The centre tap k = 24 is 1600.
- R4: Delay-line positions that would hold samples from before the most recent reset release contribute zero to a result.
- R5: The sum is scaled by adding 512 and shifting arithmetically right by 10, so an exact half rounds toward positive infinity (0.5 → 1, −0.5 → 0, −1.5 → −1).
- R6: A scaled value above 32767 is output as 32767, and one below −32768 is output as −32768.
- R7: `out_vld` is high for a single clock. It rises on the 28th rising edge after the edge that took the decimating strobe. `out_smp` does not change between pulses.
- R8: Strobes that do not complete a group of eight may come on consecutive clocks. After a decimating strobe, the next strobe must come at least 26 clocks later, and with that spacing it does not disturb the result being computed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | One-clock strobe; the sample on `in_smp` is accepted |
| in_smp | input | 12 | Signed two's-complement input sample |
| out_vld | output | 1 | One-clock pulse marking a new decimated result |
| out_smp | output | 16 | Signed two's-complement filtered result, held between pulses |

## Verification
The checks assume the strobe spacing of R8: once a decimating strobe is taken, no strobe arrives while the tap sequence is reading the delay line. The assertion on that window treats an early strobe as a caller error, not as a state the design recovers from. The stimulus follows the rule in its send task. A strobe that completes a group of eight is always followed by 26 idle clocks, the minimum allowed. Other strobes are spaced one to three clocks apart, which also covers back-to-back input. Resets are applied only after every expected result has come out.

// File: rtl/lpd_pkg.sv
package lpd_pkg;
  localparam int SMP_W     = 12;
  localparam int TAPS      = 49;
  localparam int DECIM     = 8;
  localparam int COEF_W    = 16;
  localparam int COEF_STEP = 64;
  localparam int OUT_W     = 16;
  localparam int SHIFT     = 10;

  // triangular symmetric lowpass kernel: weight grows toward the centre tap
  function automatic int coef_of(input int idx, input int taps, input int step);
    int m;
    m = (idx <= (taps - 1) / 2) ? idx : (taps - 1 - idx);
    return step * (m + 1);
  endfunction
endpackage

// File: rtl/lpd_delay_ram.sv
module lpd_delay_ram #(
  parameter int W     = 12,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_a,
  output logic [W-1:0]  rdata_b
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata_a <= mem[raddr_a];
    rdata_b <= mem[raddr_b];
  end
endmodule

// File: rtl/lpd_seq.sv
module lpd_seq #(
  parameter int TAPS  = 49,
  parameter int DECIM = 8,
  parameter int AW    = 6,
  localparam int HALF = (TAPS - 1) / 2,
  localparam int SW   = $clog2(HALF + 1),
  localparam int FW   = $clog2(TAPS + 1),
  localparam int PW   = (DECIM > 1) ? $clog2(DECIM) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_vld,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_a,
  output logic [AW-1:0] rd_b,
  output logic [SW-1:0] tap_idx,
  output logic          ok_a,
  output logic          ok_b,
  output logic          iss_vld,
  output logic          iss_first,
  output logic          iss_last,
  output logic          busy
);
  logic [AW-1:0] wr_ptr, base;
  logic [PW-1:0] phase;
  logic [FW-1:0] fill;
  logic [SW-1:0] step;
  logic          wrap;

  assign wrap = (phase == PW'(DECIM - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      base   <= '0;
      phase  <= '0;
      fill   <= '0;
      busy   <= 1'b0;
      step   <= '0;
    end else begin
      if (busy) begin
        if (step == SW'(HALF)) busy <= 1'b0;
        else                   step <= step + 1'b1;
      end
      if (in_vld) begin
        wr_ptr <= wr_ptr + 1'b1;
        base   <= wr_ptr;
        if (fill != FW'(TAPS)) fill <= fill + 1'b1;
        phase  <= wrap ? '0 : phase + 1'b1;
        if (wrap) begin
          busy <= 1'b1;
          step <= '0;
        end
      end
    end
  end

  assign wr_en     = in_vld;
  assign wr_addr   = wr_ptr;
  assign rd_a      = base - AW'(step);
  assign rd_b      = base - AW'(TAPS - 1 - int'(step));
  assign tap_idx   = step;
  assign ok_a      = int'(step) < int'(fill);
  assign ok_b      = (step != SW'(HALF)) && ((TAPS - 1 - int'(step)) < int'(fill));
  assign iss_vld   = busy;
  assign iss_first = (step == '0);
  assign iss_last  = (step == SW'(HALF));

  // R8: caller keeps strobes away while taps are still being read
  a_r8_no_strobe_busy: assert property (@(posedge clk) disable iff (rst)
    in_vld |-> !busy);
  // R4: the tap sequence never starts before any sample has been written
  a_r4_fill_on_start: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> fill != '0);
endmodule

// File: rtl/lpd_mac.sv
module lpd_mac #(
  parameter int SMP_W     = 12,
  parameter int COEF_W    = 16,
  parameter int OUT_W     = 16,
  parameter int SHIFT     = 10,
  parameter int TAPS      = 49,
  parameter int COEF_STEP = 64,
  parameter int SW        = 5,
  localparam int PROD_W   = SMP_W + 1 + COEF_W,
  localparam int ACC_W    = PROD_W + $clog2(TAPS)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    iss_vld,
  input  logic                    iss_first,
  input  logic                    iss_last,
  input  logic [SW-1:0]           tap_idx,
  input  logic                    ok_a,
  input  logic                    ok_b,
  input  logic signed [SMP_W-1:0] smp_a,
  input  logic signed [SMP_W-1:0] smp_b,
  output logic                    out_vld,
  output logic signed [OUT_W-1:0] out_data
);
  localparam logic signed [ACC_W-1:0] HALF_LSB = ACC_W'(1) <<< (SHIFT - 1);
  localparam logic signed [ACC_W-1:0] MAXV     = (ACC_W'(1) <<< (OUT_W - 1)) - ACC_W'(1);
  localparam logic signed [ACC_W-1:0] MINV     = -(ACC_W'(1) <<< (OUT_W - 1));

  // stage 1: aligned with the synchronous RAM read
  logic s1_vld, s1_first, s1_last, s1_ok_a, s1_ok_b;
  logic signed [COEF_W-1:0] s1_coef;
  // stage 2: pre-add and multiply
  logic s2_vld, s2_first, s2_last;
  logic signed [PROD_W-1:0] s2_prod;
  // stage 3: accumulate
  logic s3_vld, s3_last;
  logic signed [ACC_W-1:0] acc;

  logic signed [SMP_W:0]   opa, opb, pre;
  logic signed [ACC_W-1:0] prod_x, rnd_sum, rnd;

  assign opa    = s1_ok_a ? {smp_a[SMP_W-1], smp_a} : '0;
  assign opb    = s1_ok_b ? {smp_b[SMP_W-1], smp_b} : '0;
  assign pre    = opa + opb;
  assign prod_x = {{(ACC_W - PROD_W){s2_prod[PROD_W-1]}}, s2_prod};
  assign rnd_sum = acc + HALF_LSB;
  assign rnd    = rnd_sum >>> SHIFT;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld <= 1'b0; s1_first <= 1'b0; s1_last <= 1'b0;
      s1_ok_a <= 1'b0; s1_ok_b <= 1'b0; s1_coef <= '0;
      s2_vld <= 1'b0; s2_first <= 1'b0; s2_last <= 1'b0; s2_prod <= '0;
      s3_vld <= 1'b0; s3_last <= 1'b0; acc <= '0;
      out_vld <= 1'b0; out_data <= '0;
    end else begin
      s1_vld   <= iss_vld;
      s1_first <= iss_first;
      s1_last  <= iss_last;
      s1_ok_a  <= ok_a;
      s1_ok_b  <= ok_b;
      s1_coef  <= COEF_W'(lpd_pkg::coef_of(int'(tap_idx), TAPS, COEF_STEP));

      s2_vld   <= s1_vld;
      s2_first <= s1_first;
      s2_last  <= s1_last;
      s2_prod  <= pre * s1_coef;

      s3_vld   <= s2_vld;
      s3_last  <= s2_last;
      if (s2_vld) acc <= s2_first ? prod_x : acc + prod_x;

      out_vld <= s3_vld && s3_last;
      if (s3_vld && s3_last) begin
        if (rnd > MAXV)      out_data <= MAXV[OUT_W-1:0];
        else if (rnd < MINV) out_data <= MINV[OUT_W-1:0];
        else                 out_data <= rnd[OUT_W-1:0];
      end
    end
  end

  // R7: a result is flagged for exactly one clock
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
    out_vld |=> !out_vld);
  // R7: output word only moves together with the valid pulse
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    !out_vld |-> $stable(out_data));
  // R3: a sum is seeded by its first product before it is published
  a_r3_first_then_last: assert property (@(posedge clk) disable iff (rst)
    (s2_vld && s2_last) |-> $past(s2_vld));
endmodule

// File: rtl/lpd_decim_fir.sv
module lpd_decim_fir #(
  parameter int SMP_W     = lpd_pkg::SMP_W,
  parameter int TAPS      = lpd_pkg::TAPS,
  parameter int DECIM     = lpd_pkg::DECIM,
  parameter int COEF_W    = lpd_pkg::COEF_W,
  parameter int COEF_STEP = lpd_pkg::COEF_STEP,
  parameter int OUT_W     = lpd_pkg::OUT_W,
  parameter int SHIFT     = lpd_pkg::SHIFT
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_vld,
  input  logic signed [SMP_W-1:0] in_smp,
  output logic                    out_vld,
  output logic signed [OUT_W-1:0] out_smp
);
  localparam int AW    = $clog2(TAPS);
  localparam int DEPTH = 1 << AW;
  localparam int HALF  = (TAPS - 1) / 2;
  localparam int SW    = $clog2(HALF + 1);

  logic          wr_en, ok_a, ok_b, iss_vld, iss_first, iss_last, busy;
  logic [AW-1:0] wr_addr, rd_a, rd_b;
  logic [SW-1:0] tap_idx;
  logic [SMP_W-1:0] rdata_a, rdata_b;

  lpd_seq #(.TAPS(TAPS), .DECIM(DECIM), .AW(AW)) seq_i (
    .clk(clk), .rst(rst), .in_vld(in_vld),
    .wr_en(wr_en), .wr_addr(wr_addr), .rd_a(rd_a), .rd_b(rd_b),
    .tap_idx(tap_idx), .ok_a(ok_a), .ok_b(ok_b),
    .iss_vld(iss_vld), .iss_first(iss_first), .iss_last(iss_last), .busy(busy)
  );

  lpd_delay_ram #(.W(SMP_W), .DEPTH(DEPTH)) ram_i (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(in_smp),
    .raddr_a(rd_a), .raddr_b(rd_b), .rdata_a(rdata_a), .rdata_b(rdata_b)
  );

  lpd_mac #(.SMP_W(SMP_W), .COEF_W(COEF_W), .OUT_W(OUT_W), .SHIFT(SHIFT),
            .TAPS(TAPS), .COEF_STEP(COEF_STEP), .SW(SW)) mac_i (
    .clk(clk), .rst(rst), .iss_vld(iss_vld), .iss_first(iss_first),
    .iss_last(iss_last), .tap_idx(tap_idx), .ok_a(ok_a), .ok_b(ok_b),
    .smp_a(rdata_a), .smp_b(rdata_b), .out_vld(out_vld), .out_data(out_smp)
  );

  // R2: each result closes a tap sequence started by a decimating strobe
  a_r2_result_after_seq: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> ($past(busy, 4) && !$past(busy, 3)));
endmodule

// File: tb/lpd_decim_fir_tb.sv
`timescale 1ns/1ps
module lpd_decim_fir_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_vld = 1'b0;
  logic signed [11:0] in_smp = '0;
  logic out_vld;
  logic signed [15:0] out_smp;

  lpd_decim_fir dut_i (.clk(clk), .rst(rst), .in_vld(in_vld), .in_smp(in_smp),
                       .out_vld(out_vld), .out_smp(out_smp));

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { int val; int due; string tag; } exp_t;
  exp_t sbq[$];
  int hist[$];
  int checks = 0, fails = 0, nin = 0, pushed = 0, seen = 0;
  string cur_tag = "R3";
  logic prev_vld = 1'b0;
  logic signed [15:0] last_out = '0;

  function automatic int hk(int k);
    return 64 * (((k <= 24) ? k : 48 - k) + 1);
  endfunction

  function automatic int model();
    longint acc = 0;
    longint r;
    int n = hist.size();
    for (int k = 0; k < 49 && k < n; k++) acc += longint'(hk(k)) * hist[n-1-k];
    r = (acc + 512) >>> 10;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return int'(r);
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // driver: called at a falling edge, returns at a falling edge
  task automatic send(int x, int g);
    int gap;
    exp_t e;
    gap = ((nin % 8) == 7) ? 26 : g;
    in_vld = 1'b1;
    in_smp = 12'(x);
    hist.push_back(x);
    nin++;
    if ((nin % 8) == 0) begin
      e.val = model(); e.due = cyc + 1 + 28; e.tag = cur_tag;
      sbq.push_back(e);
      pushed++;
    end
    @(negedge clk);
    in_vld = 1'b0;
    repeat (gap - 1) @(negedge clk);
  endtask

  task automatic drain();
    repeat (40) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    hist.delete();
    nin = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst) begin
      prev_vld <= 1'b0;
      last_out <= '0;
    end else begin
      if (out_vld) begin
        exp_t e;
        seen++;
        chk(!prev_vld, "R7 pulse width", int'(prev_vld), 0);
        if (sbq.size() == 0) begin
          chk(1'b0, "R2 unexpected result", int'(out_smp), 0);
        end else begin
          e = sbq.pop_front();
          chk(int'(out_smp) == e.val, e.tag, int'(out_smp), e.val);
          chk(cyc == e.due, "R7 latency", cyc, e.due);
        end
        last_out <= out_smp;
      end else begin
        if (out_smp != last_out) chk(1'b0, "R7 hold", int'(out_smp), int'(last_out));
      end
      prev_vld <= out_vld;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    chk(out_vld == 1'b0, "R1 vld in reset", int'(out_vld), 0);
    do_reset();
    chk(out_vld == 1'b0, "R1 vld after reset", int'(out_vld), 0);
    chk(out_smp == 16'sd0, "R1 data after reset", int'(out_smp), 0);

    cur_tag = "R4 R3 impulse";
    send(1000, 3);
    for (int i = 0; i < 55; i++) send(0, 3);
    drain();

    cur_tag = "R3 dc";
    for (int i = 0; i < 64; i++) send(400, 2);
    drain();

    cur_tag = "R3 R6 mixed";
    for (int i = 0; i < 64; i++) send(((i * 937) % 4096) - 2048, 3);
    drain();

    cur_tag = "R6 positive saturation";
    for (int i = 0; i < 56; i++) send(2047, 2);
    drain();
    cur_tag = "R6 negative saturation";
    for (int i = 0; i < 56; i++) send(-2048, 2);
    drain();

    cur_tag = "R8 back-to-back";
    for (int i = 0; i < 64; i++) send((i * 61) % 2000 - 1000, 1);
    drain();

    // R4: reset mid-stream; previous samples must not leak
    do_reset();
    cur_tag = "R4 after reset";
    for (int i = 0; i < 8; i++) send(100, 2);
    drain();
    chk(last_out == 16'sd225, "R4 fixed value", int'(last_out), 225);

    // R5: exact halves
    do_reset();
    cur_tag = "R5 +0.5";
    for (int i = 0; i < 7; i++) send(0, 2);
    send(8, 2);
    drain();
    chk(last_out == 16'sd1, "R5 +0.5 fixed", int'(last_out), 1);
    do_reset();
    cur_tag = "R5 -0.5";
    for (int i = 0; i < 7; i++) send(0, 2);
    send(-8, 2);
    drain();
    chk(last_out == 16'sd0, "R5 -0.5 fixed", int'(last_out), 0);
    do_reset();
    cur_tag = "R5 -1.5";
    for (int i = 0; i < 7; i++) send(0, 2);
    send(-24, 2);
    drain();
    chk(last_out == -16'sd1, "R5 -1.5 fixed", int'(last_out), -1);

    chk(seen == pushed, "R2 result count", seen, pushed);
    chk(sbq.size() == 0, "R2 pending results", sbq.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule